// File: doc/BRIEF.md
# Periodic Alarm Countdown with Shared Interrupt Pin

This block counts down a 24-bit value once per second and raises a sticky alarm flag each time the count runs out. A seed register holds the period. The seed is written one byte at a time. When the count expires, the seed is reloaded automatically, so the alarm repeats with a period of `seed` seconds. The flag stays set until software writes a 0 to it. Writing a 1 to the flag does nothing.

One open-drain pin is shared between two uses. In interrupt mode, the pin is pulled low while the flag is set, but only when both the counter enable and the interrupt enable are on. In square-wave mode, the pin follows one of four divider taps, chosen by a 2-bit rate code, as long as the oscillator is running. The register bank around the block holds the control bits and gives them their power-up values: interrupt mode on, rate code 11, and both enables off. Software reads the count through a capture strobe. The strobe takes a snapshot of the count while the counter keeps running.

Top module: `alarm_irq_unit`

## Requirements
- R1: Pulsing `seedByteWe[k]` stores `seedByteData` into seed bits [8k+7:8k], where byte 0 is the least significant. A seed write leaves the running count untouched.
- R2: In the cycle where `ctlRunEn` is first seen high after being low, the count loads the seed value. This load takes priority over a tick in the same cycle.
- R3: The count drops by one on each `secTick` cycle, but only while `ctlRunEn`=1 and the seed is nonzero. Ticks are ignored when the enable is 0 or the seed is 0, and the count never changes without a tick.
- R4: A tick that finds the count at 1 sets `alarmFlag` and reloads the seed. With seed N, the flag rises on the Nth tick after enabling, and the flag only ever rises on a tick.
- R5: `alarmFlag` stays set until a flag write (`flagWe`=1) with `flagWrData`=0 clears it. A flag write with data 1 has no effect. An alarm in the same cycle as a clear leaves the flag set.
- R6: Pulsing `rdLatch` copies the count into `rdValue` on the next cycle. Otherwise `rdValue` holds its value.
- R7: With `ctlIrqMode`=1, `pinPullLow` equals `alarmFlag` AND `ctlRunEn` AND `ctlIrqEn`; otherwise the pin is released.
- R8: With `ctlIrqMode`=0, `pinPullLow` = `oscOn` AND NOT `divTaps[ctlRate]`. The tap index is 0 for 1 Hz, 1 for 4.096 kHz, 2 for 8.192 kHz and 3 for 32.768 kHz. With the oscillator off, the pin is released.
- R9: After reset, `alarmFlag`=0, `rdValue`=0, and the seed and count are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedByteWe | input | 3 | Per-byte seed write strobes |
| seedByteData | input | 8 | Seed write data |
| ctlRunEn | input | 1 | Counter enable |
| ctlIrqMode | input | 1 | 1 = interrupt mode, 0 = square wave |
| ctlRate | input | 2 | Square-wave tap select |
| ctlIrqEn | input | 1 | Interrupt enable |
| oscOn | input | 1 | Oscillator running |
| secTick | input | 1 | One-cycle 1 Hz pulse |
| divTaps | input | 4 | Divider tap levels (1 Hz, 4.096k, 8.192k, 32.768k) |
| flagWe | input | 1 | Flag write strobe |
| flagWrData | input | 1 | Flag write data (only 0 acts) |
| rdLatch | input | 1 | Count capture strobe |
| alarmFlag | output | 1 | Sticky alarm flag |
| rdValue | output | 24 | Captured count |
| pinPullLow | output | 1 | 1 = pull the shared pin low |

## Verification
The bench goes after the off-by-one risk in the reload. If the design fired at count 0 instead of 1, the flag would rise one tick late, on tick 4 for seed 3. It also checks that a seed write does not leak into a running count; a design that loaded the count on every seed write would show the new seed at the next capture. It tests a simultaneous alarm and clear, which a clear-wins priority would lose, and a write of 1 to the flag, which a plain register write would obey. It also checks that ticks stall both with a zero seed and with the enable off. Finally, it walks every rate code against complementary tap patterns, so a swapped tap index or a missing oscillator gate shows up on the pin.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  typedef struct packed {
    logic loadSeed;
    logic decCount;
    logic reloadSeed;
    logic setFlag;
    logic clrFlag;
    logic capture;
  } alarmStrobes_t;
endpackage

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlRunEn,
  input  logic          secTick,
  input  logic          flagWe,
  input  logic          flagWrData,
  input  logic          rdLatch,
  input  logic          countIsOne,
  input  logic          countIsZero,
  input  logic          seedIsZero,
  output alarmStrobes_t strobes
);
  logic runEnQ;
  logic loadNow;
  logic tickRun;

  always_ff @(posedge clk) begin
    if (!rstN) runEnQ <= 1'b0;
    else       runEnQ <= ctlRunEn;
  end

  // Enable edge loads the seed; it wins over a tick in the same cycle.
  assign loadNow = ctlRunEn & ~runEnQ;
  assign tickRun = ctlRunEn & ~seedIsZero & secTick & ~loadNow;

  always_comb begin
    strobes.loadSeed   = loadNow;
    strobes.reloadSeed = tickRun & (countIsOne | countIsZero);
    strobes.setFlag    = tickRun & countIsOne;
    strobes.decCount   = tickRun & ~countIsOne & ~countIsZero;
    strobes.clrFlag    = flagWe & ~flagWrData;
    strobes.capture    = rdLatch;
  end
endmodule

// File: rtl/alarm_irq_datapath.sv
module alarm_irq_datapath
  import alarm_irq_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  localparam int SLOTS = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOTS-1:0]  seedByteWe,
  input  logic [BYTE_W-1:0] seedByteData,
  input  alarmStrobes_t     strobes,
  output logic              countIsOne,
  output logic              countIsZero,
  output logic              seedIsZero,
  output logic              alarmFlag,
  output logic [CNT_W-1:0]  rdValue
);
  logic [CNT_W-1:0] seedReg;
  logic [CNT_W-1:0] countReg;

  for (genvar k = 0; k < SLOTS; k++) begin : g_seedByte
    always_ff @(posedge clk) begin
      if (!rstN)              seedReg[k*BYTE_W +: BYTE_W] <= '0;
      else if (seedByteWe[k]) seedReg[k*BYTE_W +: BYTE_W] <= seedByteData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                      countReg <= '0;
    else if (strobes.loadSeed || strobes.reloadSeed) countReg <= seedReg;
    else if (strobes.decCount)                       countReg <= countReg - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                alarmFlag <= 1'b0;
    else if (strobes.setFlag) alarmFlag <= 1'b1;
    else if (strobes.clrFlag) alarmFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rdValue <= '0;
    else if (strobes.capture) rdValue <= countReg;
  end

  assign countIsOne  = (countReg == CNT_W'(1));
  assign countIsZero = (countReg == '0);
  assign seedIsZero  = (seedReg == '0);
endmodule

// File: rtl/alarm_pin_sel.sv
module alarm_pin_sel #(
  parameter int NUM_RATES = 4,
  localparam int RATE_W   = $clog2(NUM_RATES)
) (
  input  logic                 ctlIrqMode,
  input  logic                 ctlIrqEn,
  input  logic                 ctlRunEn,
  input  logic                 oscOn,
  input  logic [RATE_W-1:0]    ctlRate,
  input  logic [NUM_RATES-1:0] divTaps,
  input  logic                 alarmFlag,
  output logic                 pinPullLow
);
  logic irqPull;
  logic sqPull;

  assign irqPull = alarmFlag & ctlRunEn & ctlIrqEn;
  assign sqPull  = oscOn & ~divTaps[ctlRate];
  assign pinPullLow = ctlIrqMode ? irqPull : sqPull;
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int BYTE_W    = 8,
  parameter int NUM_RATES = 4,
  localparam int SLOTS    = CNT_W / BYTE_W,
  localparam int RATE_W   = $clog2(NUM_RATES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SLOTS-1:0]     seedByteWe,
  input  logic [BYTE_W-1:0]    seedByteData,
  input  logic                 ctlRunEn,
  input  logic                 ctlIrqMode,
  input  logic [RATE_W-1:0]    ctlRate,
  input  logic                 ctlIrqEn,
  input  logic                 oscOn,
  input  logic                 secTick,
  input  logic [NUM_RATES-1:0] divTaps,
  input  logic                 flagWe,
  input  logic                 flagWrData,
  input  logic                 rdLatch,
  output logic                 alarmFlag,
  output logic [CNT_W-1:0]     rdValue,
  output logic                 pinPullLow
);
  alarmStrobes_t strobes;
  logic countIsOne;
  logic countIsZero;
  logic seedIsZero;

  alarm_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlRunEn(ctlRunEn), .secTick(secTick),
    .flagWe(flagWe), .flagWrData(flagWrData), .rdLatch(rdLatch),
    .countIsOne(countIsOne), .countIsZero(countIsZero),
    .seedIsZero(seedIsZero), .strobes(strobes)
  );

  alarm_irq_datapath #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .seedByteWe(seedByteWe),
    .seedByteData(seedByteData), .strobes(strobes),
    .countIsOne(countIsOne), .countIsZero(countIsZero),
    .seedIsZero(seedIsZero), .alarmFlag(alarmFlag), .rdValue(rdValue)
  );

  alarm_pin_sel #(.NUM_RATES(NUM_RATES)) u_pin (
    .ctlIrqMode(ctlIrqMode), .ctlIrqEn(ctlIrqEn), .ctlRunEn(ctlRunEn),
    .oscOn(oscOn), .ctlRate(ctlRate), .divTaps(divTaps),
    .alarmFlag(alarmFlag), .pinPullLow(pinPullLow)
  );
endmodule

// File: rtl/alarm_irq_unit_chk.sv
module alarm_irq_unit_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlIrqMode,
  input logic             oscOn,
  input logic             secTick,
  input logic             flagWe,
  input logic             flagWrData,
  input logic             rdLatch,
  input logic             alarmFlag,
  input logic [CNT_W-1:0] rdValue,
  input logic             pinPullLow
);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !(flagWe && !flagWrData)) |=> alarmFlag);

  assert_flag_rises_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmFlag && !secTick) |=> !alarmFlag);

  assert_read_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdLatch |=> $stable(rdValue));

  assert_irq_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlIrqMode && !alarmFlag) |-> !pinPullLow);

  assert_sq_osc_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlIrqMode && !oscOn) |-> !pinPullLow);
endmodule

bind alarm_irq_unit alarm_irq_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctlIrqMode(ctlIrqMode), .oscOn(oscOn),
  .secTick(secTick), .flagWe(flagWe), .flagWrData(flagWrData),
  .rdLatch(rdLatch), .alarmFlag(alarmFlag), .rdValue(rdValue),
  .pinPullLow(pinPullLow)
);

// File: tb/alarm_irq_unit_bench.sv
module alarm_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  seedByteWe = '0;
  logic [7:0]  seedByteData = '0;
  logic        ctlRunEn = 1'b0;
  logic        ctlIrqMode = 1'b1;
  logic [1:0]  ctlRate = 2'b11;
  logic        ctlIrqEn = 1'b0;
  logic        oscOn = 1'b1;
  logic        secTick = 1'b0;
  logic [3:0]  divTaps = '0;
  logic        flagWe = 1'b0;
  logic        flagWrData = 1'b0;
  logic        rdLatch = 1'b0;
  logic        alarmFlag;
  logic [23:0] rdValue;
  logic        pinPullLow;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  alarm_irq_unit u_alarm_irq_unit (.*);

  // {rate[1:0], taps[3:0], oscOn, expectedPull}
  localparam logic [7:0] SQ_VEC [9] = '{
    {2'd0, 4'b0001, 1'b1, 1'b0}, {2'd0, 4'b1110, 1'b1, 1'b1},
    {2'd1, 4'b0010, 1'b1, 1'b0}, {2'd1, 4'b1101, 1'b1, 1'b1},
    {2'd2, 4'b0100, 1'b1, 1'b0}, {2'd2, 4'b1011, 1'b1, 1'b1},
    {2'd3, 4'b1000, 1'b1, 1'b0}, {2'd3, 4'b0111, 1'b1, 1'b1},
    {2'd3, 4'b0111, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeSeed(input logic [23:0] v);
    for (int k = 0; k < 3; k++) begin
      seedByteWe = 3'(1 << k);
      seedByteData = v[k*8 +: 8];
      step();
    end
    seedByteWe = '0;
  endtask

  task automatic capture(output logic [23:0] v);
    rdLatch = 1'b1;
    step();
    rdLatch = 1'b0;
    v = rdValue;
  endtask

  task automatic tick();
    secTick = 1'b1;
    step();
    secTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [23:0] rv;
    @(negedge clk);
    step();
    rstN = 1'b1;
    step();
    // R9 reset state
    check("R9 flag", 32'(alarmFlag), 0);
    check("R9 rdValue", 32'(rdValue), 0);
    check("R7 pin released at reset", 32'(pinPullLow), 0);
    capture(rv);
    check("R9 count zero", 32'(rv), 0);

    // square-wave table, R8
    ctlIrqMode = 1'b0;
    for (int i = 0; i < 9; i++) begin
      ctlRate = SQ_VEC[i][7:6];
      divTaps = SQ_VEC[i][5:2];
      oscOn   = SQ_VEC[i][1];
      #1;
      check("R8 square pin", 32'(pinPullLow), 32'(SQ_VEC[i][0]));
    end
    @(negedge clk);
    ctlIrqMode = 1'b1;
    oscOn = 1'b1;

    // R1 byte order and R2 load on enable edge
    writeSeed(24'h123456);
    ctlRunEn = 1'b1;
    step();
    capture(rv);
    check("R1/R2 seed loaded", 32'(rv), 32'h123456);
    tick();
    capture(rv);
    check("R3 one tick", 32'(rv), 32'h123455);
    repeat (4) step();
    capture(rv);
    check("R3 no tick no change", 32'(rv), 32'h123455);
    ctlRunEn = 1'b0;
    tick();
    capture(rv);
    check("R3 disabled ignores tick", 32'(rv), 32'h123455);
    writeSeed(24'h000003);
    capture(rv);
    check("R1 seed write leaves count", 32'(rv), 32'h123455);

    // R2 edge with simultaneous tick: load wins
    ctlRunEn = 1'b1;
    secTick = 1'b1;
    step();
    secTick = 1'b0;
    capture(rv);
    check("R2 load beats tick", 32'(rv), 3);

    // R4 period
    tick();
    tick();
    check("R4 no flag before expiry", 32'(alarmFlag), 0);
    tick();
    check("R4 flag on third tick", 32'(alarmFlag), 1);
    capture(rv);
    check("R4 reloaded", 32'(rv), 3);

    // R7 interrupt pin
    ctlIrqEn = 1'b1;
    #1;
    check("R7 pin low with flag", 32'(pinPullLow), 1);
    ctlRunEn = 1'b0;
    #1;
    check("R7 released without enable", 32'(pinPullLow), 0);
    @(negedge clk);
    ctlRunEn = 1'b1;
    ctlIrqEn = 1'b0;
    #1;
    check("R7 released without irq enable", 32'(pinPullLow), 0);
    @(negedge clk);

    // R5 flag write semantics
    flagWe = 1'b1; flagWrData = 1'b1;
    step();
    flagWe = 1'b0;
    check("R5 write one ignored", 32'(alarmFlag), 1);
    flagWe = 1'b1; flagWrData = 1'b0;
    step();
    flagWe = 1'b0;
    check("R5 write zero clears", 32'(alarmFlag), 0);

    // R5 set beats clear (count is 3 after reload)
    tick();
    tick();
    flagWe = 1'b1; flagWrData = 1'b0;
    tick();
    flagWe = 1'b0;
    check("R5 alarm beats clear", 32'(alarmFlag), 1);

    // R6 hold without capture
    rv = rdValue;
    tick();
    step();
    check("R6 rdValue holds", 32'(rdValue), 32'(rv));
    capture(rv);
    check("R6 capture updates", 32'(rv), 2);

    // R3 zero seed stalls
    flagWe = 1'b1; flagWrData = 1'b0;
    step();
    flagWe = 1'b0;
    ctlRunEn = 1'b0;
    writeSeed(24'h000000);
    ctlRunEn = 1'b1;
    step();
    repeat (3) tick();
    capture(rv);
    check("R3 zero seed count stays", 32'(rv), 0);
    check("R3 zero seed no alarm", 32'(alarmFlag), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule